// File: doc/BRIEF.md
# DC Offset Removal Filter with Estimate Hold

This block removes the DC component from a stream of signed audio samples, one independent lane per channel, placed directly after a decimation filter. Each lane keeps a running DC estimate. Every accepted sample leaves the block with that estimate subtracted, and the estimate then moves a small fraction of the way toward the new sample. The fraction is 2^-K, so the tracker is a first-order leaky integrator. The integrator is kept at K extra fractional bits so that truncation does not pile up into drift.

Each lane has a hold control. While it is high, the lane stops updating its estimate but keeps subtracting the value captured at that moment. A steady DC level then passes through with a fixed offset and is not pulled toward zero. Lowering the control resumes tracking from the held value. The difference is clamped to the signed sample range.

Top module: `dc_offset_remover`

## Requirements
- R1: A synchronous active-low reset clears every lane's estimate to zero, drives `out_valid` low and drives `out_sample` to zero. The first sample accepted after reset therefore leaves the block unchanged.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. When `in_valid` is low, `out_sample` keeps its last value.
- R3: For an accepted sample x on a lane, the lane output is clamp(x - E). E = floor(A / 2^K) is the estimate taken before this sample, and A is the lane's accumulator.
- R4: With the lane's hold bit low, an accepted sample updates the accumulator as A := A + x - E. When x differs from E, the accumulator changes.
- R5: In cycles with `in_valid` low, no accumulator changes, whatever `in_sample` and `hold` carry.
- R6: With the lane's hold bit high at an accepted sample, the accumulator keeps its value and the held E is still subtracted.
- R7: After the hold bit is lowered, tracking resumes from the held accumulator with no reset or jump.
- R8: When x - E does not fit DW signed bits, the output clamps to 2^(DW-1)-1 if the difference is positive and to -2^(DW-1) if it is negative. A difference exactly at a limit passes through unchanged.
- R9: Lane c uses bits [c*DW +: DW] of `in_sample` and `out_sample` and bit c of `hold`. Holding one lane does not affect any other lane.
- R10: While held, a constant input yields the same output on every sample, with no decay toward zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A sample for every lane is present this cycle |
| in_sample | input | NCH*DW | Signed samples, lane c at [c*DW +: DW] |
| hold | input | NCH | Per-lane estimate hold, bit c for lane c |
| out_valid | output | 1 | Corrected samples present this cycle |
| out_sample | output | NCH*DW | Corrected signed samples, same lane layout |

## Verification
The embedded properties check four things on every clock. The accumulator stays still on idle cycles and on held samples. It moves on any tracked sample that differs from the estimate. It stays inside the range that keeps the estimate a legal sample. Two further properties check that `out_valid` trails `in_valid` by one cycle and that the output's sign matches the sign of the sample-minus-estimate difference. Only the bench's scenarios can show the actual numeric values, because those depend on the accumulated history. These values are: the convergence of a DC step, the exact fixed offset during a hold, the seamless resumption after one, the output clamp exactly at the range limits, and a reset in the middle of a run returning the estimate to zero.

// File: rtl/dcr_pkg.sv
// Package: shared definitions for the DC offset removal filter.
// Assumes: nothing beyond IEEE 1800-2017.
package dcr_pkg;

    // Accumulator action selected for a lane in a given cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_TRACK = 2'd1,
        ACC_HOLD  = 2'd2
    } acc_mode_e;

    // Default tracker shift: the estimate moves 2^-10 of the error per sample.
    localparam int unsigned DCR_DEF_SHIFT = 10;

endpackage

// File: rtl/dcr_tracker.sv
// Module: dcr_tracker
// Keeps one lane's DC estimate as a leaky integrator with K fractional bits.
// On a tracked sample: acc += x - (acc >>> K). The estimate is acc >>> K.
// Assumes: DW >= 2, K >= 1. The accumulator width DW+K+1 holds every
// reachable value, so the estimate always fits DW bits.
module dcr_tracker
    import dcr_pkg::*;
#(
    parameter int unsigned DW = 24,
    parameter int unsigned K  = DCR_DEF_SHIFT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smp,
    input  logic                 hold,
    output logic signed [DW-1:0] est
);
    localparam int unsigned AW = DW + K + 1;

    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] err;
    logic signed [AW-1:0] acc_next;
    acc_mode_e            mode;

    // Estimate: integer part of the scaled accumulator.
    assign est = DW'(acc_q >>> K);

    // Error and next accumulator for a tracked sample.
    always_comb begin
        err      = AW'(smp) - AW'(est);
        acc_next = acc_q + err;
    end

    // Decode this cycle's accumulator action.
    always_comb begin
        if (!smp_valid)  mode = ACC_IDLE;
        else if (hold)   mode = ACC_HOLD;
        else             mode = ACC_TRACK;
    end

    // Accumulator register: cleared by reset, advanced only when tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            case (mode)
                ACC_TRACK: acc_q <= acc_next;
                default:   acc_q <= acc_q;
            endcase
        end
    end

    // R5: idle cycles leave the estimate untouched.
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(acc_q));

    // R6: a held sample leaves the estimate untouched.
    assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && hold) |=> $stable(acc_q));

    // R4: a tracked sample away from the estimate moves the accumulator.
    assert_track_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !hold && (smp != est)) |=> !$stable(acc_q));

    // R3: the accumulator never reaches its top bit, so the estimate is a legal sample.
    assert_est_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q[AW-1] == acc_q[AW-2]);

endmodule

// File: rtl/dcr_sat_sub.sv
// Module: dcr_sat_sub
// Combinational a - b with the result clamped to the DW-bit signed range.
// Assumes: DW >= 2; both operands are DW-bit two's complement.
module dcr_sat_sub #(
    parameter int unsigned DW = 24
) (
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [DW-1:0] y
);
    localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW:0] diff;
    logic               ovf;

    // One-bit-wider difference and overflow detection from its top two bits.
    always_comb begin
        diff = (DW+1)'(a) - (DW+1)'(b);
        ovf  = diff[DW] ^ diff[DW-1];
    end

    // Clamp by the sign of the wide difference when it leaves the range.
    always_comb begin
        if (ovf) y = diff[DW] ? MINV : MAXV;
        else     y = diff[DW-1:0];
    end

endmodule

// File: rtl/dcr_channel.sv
// Module: dcr_channel
// One lane: subtracts the tracker's current estimate from each accepted
// sample, clamps the result and registers it.
// Assumes: smp_valid is shared with the other lanes; the output register loads
// only on accepted samples and otherwise holds.
module dcr_channel
    import dcr_pkg::*;
#(
    parameter int unsigned DW = 24,
    parameter int unsigned K  = DCR_DEF_SHIFT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smp,
    input  logic                 hold,
    output logic signed [DW-1:0] res
);
    logic signed [DW-1:0] est;
    logic signed [DW-1:0] corr;

    dcr_tracker #(.DW(DW), .K(K)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp       (smp),
        .hold      (hold),
        .est       (est)
    );

    dcr_sat_sub #(.DW(DW)) u_sub (
        .a (smp),
        .b (est),
        .y (corr)
    );

    // Output register: cleared by reset, loaded with the corrected sample.
    always_ff @(posedge clk) begin
        if (!rst_n)         res <= '0;
        else if (smp_valid) res <= corr;
    end

    // R8: a non-negative difference never yields a negative output.
    assert_sign_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (smp >= est)) |=> !res[DW-1]);

    // R8: a negative difference always yields a negative output.
    assert_sign_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (smp < est)) |=> res[DW-1]);

endmodule

// File: rtl/dc_offset_remover.sv
// Module: dc_offset_remover (top)
// Multi-lane DC offset removal with a per-lane estimate hold. All lanes share
// one valid strobe; lane c occupies bits [c*DW +: DW] and hold bit c.
// Assumes: samples come from a decimation filter at most one per clock.
module dc_offset_remover
    import dcr_pkg::*;
#(
    parameter int unsigned NCH = 2,
    parameter int unsigned DW  = 24,
    parameter int unsigned K   = DCR_DEF_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [NCH*DW-1:0] in_sample,
    input  logic [NCH-1:0]    hold,
    output logic              out_valid,
    output logic [NCH*DW-1:0] out_sample
);
    localparam int unsigned BUSW = NCH * DW;

    logic [BUSW-1:0] lane_res;

    // One independent lane per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic signed [DW-1:0] lane_out;

        dcr_channel #(.DW(DW), .K(K)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (in_valid),
            .smp       (in_sample[c*DW +: DW]),
            .hold      (hold[c]),
            .res       (lane_out)
        );

        assign lane_res[c*DW +: DW] = lane_out;
    end

    assign out_sample = lane_res;

    // Output strobe: one cycle behind the input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // R2: every accepted sample produces a result on the next cycle.
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no result appears without a sample the cycle before.
    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

endmodule

// File: tb/dc_offset_remover_tb.sv
// Scoreboard bench: the driver computes expected lane outputs from the
// requirement formulas and queues them; the monitor compares on out_valid.
module dc_offset_remover_tb;
    localparam int    NCH  = 2;
    localparam int    DW   = 24;
    localparam int    K    = 10;
    localparam longint MAXS = 64'sd8388607;
    localparam longint MINS = -64'sd8388608;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [NCH*DW-1:0] in_sample = '0;
    logic [NCH-1:0]    hold = '0;
    logic              out_valid;
    logic [NCH*DW-1:0] out_sample;

    dc_offset_remover #(.NCH(NCH), .DW(DW), .K(K)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .hold       (hold),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always #10 clk = ~clk;  // 50 MHz

    int     n_vec = 0;
    int     n_bad = 0;
    bit     done  = 1'b0;
    longint acc0 = 0, acc1 = 0;
    longint last0 = 0, last1 = 0;
    longint q0[$];
    longint q1[$];
    string  qt[$];

    function automatic longint satv(longint v);
        if (v > MAXS) return MAXS;
        if (v < MINS) return MINS;
        return v;
    endfunction

    function automatic longint lane(int c);
        return longint'($signed(out_sample[c*DW +: DW]));
    endfunction

    task automatic check(longint act, longint exp, string tag);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: apply one sample pair, model R3/R4/R6, queue expectations.
    task automatic drive(longint x0, longint x1, logic h0, logic h1, string tag);
        longint e0, e1;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = {DW'(x1), DW'(x0)};
        hold      = {h1, h0};
        e0 = satv(x0 - (acc0 >>> K));
        e1 = satv(x1 - (acc1 >>> K));
        if (!h0) acc0 += x0 - (acc0 >>> K);
        if (!h1) acc1 += x1 - (acc1 >>> K);
        q0.push_back(e0);
        q1.push_back(e1);
        qt.push_back(tag);
    endtask

    // Idle: junk on data and hold must be ignored; output must hold (R2, R5).
    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_sample = {DW'(longint'(12345 * (i + 3))), DW'(longint'(-777 * (i + 1)))};
            hold      = NCH'(i);
        end
        check(lane(0), last0, "R2 output holds while idle lane0");
        check(lane(1), last1, "R2 output holds while idle lane1");
    endtask

    // Monitor: pop and compare on each out_valid.
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (q0.size() == 0) begin
                n_vec++;
                n_bad++;
                $display("FAIL R2 unexpected out_valid: actual=1 expected=0");
            end else begin
                longint e0, e1;
                string  t;
                e0 = q0.pop_front();
                e1 = q1.pop_front();
                t  = qt.pop_front();
                check(lane(0), e0, {t, " lane0"});
                check(lane(1), e1, {t, " lane1"});
                last0 = e0;
                last1 = e1;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R1-all watchdog: actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(longint'(out_valid), 0, "R1 out_valid after reset");
        check(lane(0), 0, "R1 lane0 output after reset");
        check(lane(1), 0, "R1 lane1 output after reset");

        // R1: zero estimate, first sample passes unchanged
        drive(1000, -2000, 0, 0, "R1 first sample after reset");

        // R3/R4: DC step tracking with idle gaps (R5)
        for (int blk = 0; blk < 12; blk++) begin
            for (int i = 0; i < 500; i++) drive(50000, -30000, 0, 0, "R4 step tracking");
            idle(3);
        end

        // R9/R10: hold lane0 on a DC level, lane1 keeps tracking a new level
        for (int i = 0; i < 500; i++) drive(20000, 4000, 1, 0, "R10 held DC lane0, R9 lane1 tracks");
        idle(2);

        // R7: release hold, tracking resumes from the held value
        for (int i = 0; i < 300; i++) drive(20000, 4000, 0, 0, "R7 resume after hold");
        idle(2);

        // R3: alternating ramp pattern
        for (int i = 0; i < 200; i++)
            drive(longint'((i % 17) * 3001 - 24000), longint'(-(i % 11) * 5003 + 9000), 0, 0, "R3 ramp pattern");
        idle(3);

        // R1: reset mid-run clears the estimate
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        acc0 = 0;
        acc1 = 0;
        last0 = 0;
        last1 = 0;
        rst_n = 1'b1;
        drive(1000, -1000, 0, 0, "R1 first sample after mid-run reset");

        // R8: drive estimates to the rails, then hold and overrange
        for (int i = 0; i < 3000; i++) drive(MINS, MAXS, 0, 0, "R8 pre-charge");
        drive(MAXS, MINS, 1, 1, "R8 clamp beyond range");
        drive(MAXS + (acc0 >>> K), MINS + (acc1 >>> K), 1, 1, "R8 exactly at limit");
        drive(MAXS + (acc0 >>> K) - 1, MINS + (acc1 >>> K) + 1, 1, 1, "R8 one inside limit");
        drive(MINS, MAXS, 1, 1, "R8 held pass-through");
        idle(3);

        // Drain: every queued result must have appeared
        n_vec++;
        if (q0.size() != 0) begin
            n_bad++;
            $display("FAIL R2 results missing: actual=%0d expected=0", q0.size());
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule